// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Front End

This block sits between a byte-wide processor bus and the data paths of a two-channel serial controller. Software never addresses a configuration register directly. Each channel exposes a command port and a data port. A write to the command port names a register, and the next write fills that register. Each channel holds sixteen write registers and presents sixteen read registers. Status, timer mirrors and the shared interrupt-pending register are reached through the same pointer.

Bytes written to a data port leave on a one-cycle transmit strobe. Received bytes are pushed into a small per-channel FIFO, and data-port reads pop that FIFO. A loopback control returns transmitted bytes to the same channel's FIFO. The interrupt enables and the pending register live in channel A and cover both channels. A single interrupt line summarises them.

Top module: `scc_regif`

## Requirements
- R1: After reset all write registers are 0, both pointers are 0 in select mode, both FIFOs are empty, no pending bit is set, and irq_o and tx_stb_o are low.
- R2: Address bit 3 picks the channel (0 = A, 1 = B). Address bits 2:0 equal to 1 select the command port and 5 select the data port. Any other offset reads as 0 and ignores writes.
- R3: In select mode a command-port write loads the pointer from data bits 3:0 and leaves select mode. The following command-port write stores its byte into the write register named by the pointer, then resets the pointer to 0 and returns to select mode.
- R4: A command-port read returns the read register named by the pointer, then resets the pointer to 0 and returns to select mode.
- R5: Read registers 12 and 13 return the current contents of write registers 12 and 13 of the same channel. Read registers 2, 4 to 11, 14 and 15 read as 0, and so does read register 3 of channel B.
- R6: Read register 0 has bit 2 (transmitter empty) always 1, bit 0 set exactly when that channel's receive FIFO holds data, and all other bits 0. Read register 1 always reads 0.
- R7: A data-port read returns the oldest byte in that channel's FIFO and removes it, or returns 0 when the FIFO is empty. Each FIFO holds FIFO_DEPTH bytes (default 8), and a push into a full FIFO is dropped.
- R8: A data-port write drives tx_byte_o with the byte and pulses that channel's bit of tx_stb_o for exactly the next cycle.
- R9: When bit 4 of a channel's write register 14 is set, a data-port write to that channel also pushes the byte into the same channel's FIFO. That push takes the FIFO slot over an external rx_push_i in the same cycle, and the external byte is dropped.
- R10: When bit 3 of channel A write register 9 (master enable) is set and bits 4:3 of channel A write register 1 (receive mode) are non-zero, a non-empty FIFO sets its receive-pending bit in channel A read register 3 on the next cycle. The bit is 5 for channel A and 2 for channel B. irq_o is high while such a bit is set under those enables.
- R11: A data-port write sets that channel's transmit-pending bit (bit 4 for A, bit 1 for B) when the master enable is set and bit 1 of that channel's write register 1 is set. irq_o is high while a transmit-pending bit and its channel's bit 1 are set under the master enable.
- R12: A command-port read of channel A read register 3, and any data-port read, clears every pending bit in the cycle of the read. A receive-pending bit sets again one cycle later if its condition still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 4 | Bit 3 channel, bits 2:0 offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access; ignored while bus_wr_i is high |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle bus_rd_i is high |
| rx_push_i | input | 2 | Per-channel receive byte push |
| rx_byte_i | input | 16 | Received bytes, channel A in bits 7:0, channel B in bits 15:8 |
| tx_stb_o | output | 2 | Per-channel transmit strobe |
| tx_byte_o | output | 8 | Byte that accompanies tx_stb_o |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case is the cycle right after a pending-clearing data read while the FIFO still holds a byte. In that cycle the interrupt must be low, and one cycle later it must be high again. The bench loads two bytes, pops one, and samples irq_o on both sides of the re-arm edge. A second hard case is a loopback write that meets an external push in the same cycle. Only a combined stimulus task drives the bus write and rx_push_i together, and the bench then drains the FIFO to show that exactly one byte, the looped one, arrived. Pointer desynchronisation is hidden from the ports, so stray writes and bare command reads are always followed by full select-write-read sequences whose results would shift if the pointer state were wrong.

// File: rtl/scc_regif_pkg.sv
package scc_regif_pkg;
  localparam int NUM_CH  = 2;
  localparam int NUM_REG = 16;
  localparam int DW      = 8;
  localparam int ADDR_W  = 4;
  localparam int PTR_W   = $clog2(NUM_REG);

  localparam logic [2:0] OFF_CMD  = 3'd1;
  localparam logic [2:0] OFF_DATA = 3'd5;

  // register indices
  localparam int REG_STAT   = 0;
  localparam int REG_ERR    = 1;
  localparam int REG_PEND   = 3;
  localparam int REG_MODE   = 1;
  localparam int REG_MASTER = 9;
  localparam int REG_TC_LO  = 12;
  localparam int REG_TC_HI  = 13;
  localparam int REG_MISC   = 14;

  // bit positions
  localparam int STAT_RXAV  = 0;
  localparam int STAT_TXE   = 2;
  localparam int MODE_TXIE  = 1;
  localparam int MODE_RX_LO = 3;
  localparam int MODE_RX_HI = 4;
  localparam int MASTER_IE  = 3;
  localparam int MISC_LOOP  = 4;

  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/scc_rx_fifo.sv
module scc_rx_fifo #(
  parameter int DEPTH = 8,  // power of two not required
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          not_empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic full, do_push, do_pop;

  assign full        = (cnt_q == CW'(DEPTH));
  assign not_empty_o = (cnt_q != '0);
  assign do_pop      = pop_i && not_empty_o;
  assign do_push     = push_i && (!full || do_pop);
  assign head_o      = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (full && $stable(head_o))); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_empty_o && pop_i && !push_i) |=> !not_empty_o); // R7
endmodule

// File: rtl/scc_chan_ctl.sv
module scc_chan_ctl #(
  parameter int NUM_REG = 16,
  parameter int DW      = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cmd_wr_i,
  input  logic                            cmd_rd_i,
  input  logic [DW-1:0]                   wdata_i,
  output logic [$clog2(NUM_REG)-1:0]      ptr_o,
  output logic [NUM_REG-1:0][DW-1:0]      wregs_o
);
  localparam int PTR_W = $clog2(NUM_REG);

  logic             sel_pend_q;
  logic [PTR_W-1:0] ptr_q;
  logic             reg_wr;

  assign reg_wr = cmd_wr_i && sel_pend_q;
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_pend_q <= 1'b0;
      ptr_q      <= '0;
    end else if (cmd_rd_i || reg_wr) begin
      sel_pend_q <= 1'b0;
      ptr_q      <= '0;
    end else if (cmd_wr_i) begin
      sel_pend_q <= 1'b1;
      ptr_q      <= wdata_i[PTR_W-1:0];
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_wreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             wregs_o[r] <= '0;
      else if (reg_wr && ptr_q == PTR_W'(r))   wregs_o[r] <= wdata_i;
    end
  end

  AST_PTR_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr |=> (!sel_pend_q && ptr_q == '0)); // R3
  AST_SELECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !sel_pend_q && !cmd_rd_i) |=> (sel_pend_q && ptr_q == $past(wdata_i[PTR_W-1:0]))); // R3
  AST_RD_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rd_i |=> (!sel_pend_q && ptr_q == '0)); // R4
endmodule

// File: rtl/scc_irq_unit.sv
module scc_irq_unit #(
  parameter int NUM_CH = 2,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mie_i,
  input  logic [1:0]        rx_mode_i,
  input  logic [NUM_CH-1:0] txie_i,
  input  logic [NUM_CH-1:0] rx_avail_i,
  input  logic [NUM_CH-1:0] tx_evt_i,
  input  logic              clr_i,
  output logic [DW-1:0]     pend_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] rx_pend_q, tx_pend_q;
  logic rx_en;

  assign rx_en = mie_i && (rx_mode_i != 2'b00);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_pend_q[c] <= 1'b0;
        tx_pend_q[c] <= 1'b0;
      end else if (clr_i) begin
        rx_pend_q[c] <= 1'b0;
        tx_pend_q[c] <= 1'b0;
      end else begin
        if (rx_en && rx_avail_i[c])                tx_pend_q[c] <= tx_pend_q[c];
        if (rx_en && rx_avail_i[c])                rx_pend_q[c] <= 1'b1;
        if (tx_evt_i[c] && mie_i && txie_i[c])     tx_pend_q[c] <= 1'b1;
      end
    end

    AST_TX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_evt_i[c] && mie_i && txie_i[c] && !clr_i) |=> pend_o[3*(NUM_CH-1-c)+1]); // R11
  end

  // channel A occupies the upper triple; external bits stay clear
  always_comb begin
    pend_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      pend_o[3*(NUM_CH-1-c)+2] = rx_pend_q[c];
      pend_o[3*(NUM_CH-1-c)+1] = tx_pend_q[c];
    end
  end

  assign irq_o = mie_i && (((rx_mode_i != 2'b00) && (|rx_pend_q)) || (|(tx_pend_q & txie_i)));

  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pend_o == '0)); // R12
  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en && (|rx_avail_i) && !clr_i) |=> irq_o); // R10
endmodule

// File: rtl/scc_regif.sv
module scc_regif
  import scc_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic [NUM_CH-1:0]    rx_push_i,
  input  logic [NUM_CH*DW-1:0] rx_byte_i,
  output logic [NUM_CH-1:0]    tx_stb_o,
  output logic [DW-1:0]        tx_byte_o,
  output logic                 irq_o
);
  logic                                ch_sel;
  logic [2:0]                          off;
  logic                                rd_en;
  logic [NUM_CH-1:0]                   cmd_wr, cmd_rd, dat_wr, dat_rd;
  logic [NUM_CH-1:0][PTR_W-1:0]        ptr;
  logic [NUM_CH-1:0][NUM_REG-1:0][DW-1:0] wregs;
  logic [NUM_CH-1:0][DW-1:0]           rr_val, head;
  logic [NUM_CH-1:0]                   fifo_ne, fifo_push, loop_en, txie;
  logic [NUM_CH-1:0][DW-1:0]           fifo_din;
  logic [DW-1:0]                       pend;
  logic                                pend_clr;
  logic [NUM_CH-1:0]                   tx_stb_q;
  logic [DW-1:0]                       tx_byte_q;
  logic                                unused_wr;

  assign ch_sel = bus_addr_i[3];
  assign off    = bus_addr_i[2:0];
  assign rd_en  = bus_rd_i && !bus_wr_i;  // write wins on a collision

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit       = (ch_sel == 1'(c));
    assign cmd_wr[c] = bus_wr_i && hit && (off == OFF_CMD);
    assign cmd_rd[c] = rd_en    && hit && (off == OFF_CMD);
    assign dat_wr[c] = bus_wr_i && hit && (off == OFF_DATA);
    assign dat_rd[c] = rd_en    && hit && (off == OFF_DATA);

    scc_chan_ctl #(.NUM_REG(NUM_REG), .DW(DW)) u_ctl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_wr_i (cmd_wr[c]),
      .cmd_rd_i (cmd_rd[c]),
      .wdata_i  (bus_wdata_i),
      .ptr_o    (ptr[c]),
      .wregs_o  (wregs[c])
    );

    assign loop_en[c]   = wregs[c][REG_MISC][MISC_LOOP];
    assign txie[c]      = wregs[c][REG_MODE][MODE_TXIE];
    assign fifo_push[c] = (dat_wr[c] && loop_en[c]) || rx_push_i[c];
    assign fifo_din[c]  = (dat_wr[c] && loop_en[c]) ? bus_wdata_i : rx_byte_i[c*DW +: DW];

    scc_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (fifo_push[c]),
      .push_data_i (fifo_din[c]),
      .pop_i       (dat_rd[c]),
      .head_o      (head[c]),
      .not_empty_o (fifo_ne[c])
    );

    always_comb begin
      rr_val[c] = '0;
      case (ptr[c])
        PTR_W'(REG_STAT): begin
          rr_val[c][STAT_TXE]  = 1'b1;
          rr_val[c][STAT_RXAV] = fifo_ne[c];
        end
        PTR_W'(REG_ERR):   rr_val[c] = '0;
        PTR_W'(REG_PEND):  rr_val[c] = (c == 0) ? pend : '0;
        PTR_W'(REG_TC_LO): rr_val[c] = wregs[c][REG_TC_LO];
        PTR_W'(REG_TC_HI): rr_val[c] = wregs[c][REG_TC_HI];
        default:           rr_val[c] = '0;
      endcase
    end

    AST_TX_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dat_wr[c] |=> (tx_stb_o[c] && tx_byte_o == $past(bus_wdata_i))); // R8
    AST_LOOPBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dat_wr[c] && loop_en[c]) |=> fifo_ne[c]); // R9
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cmd_rd[c]) bus_rdata_o = rr_val[c];
      if (dat_rd[c]) bus_rdata_o = fifo_ne[c] ? head[c] : '0;
    end
  end

  assign pend_clr = (|dat_rd) || (cmd_rd[0] && ptr[0] == PTR_W'(REG_PEND));

  scc_irq_unit #(.NUM_CH(NUM_CH), .DW(DW)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mie_i      (wregs[0][REG_MASTER][MASTER_IE]),
    .rx_mode_i  (wregs[0][REG_MODE][MODE_RX_HI:MODE_RX_LO]),
    .txie_i     (txie),
    .rx_avail_i (fifo_ne),
    .tx_evt_i   (dat_wr),
    .clr_i      (pend_clr),
    .pend_o     (pend),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_stb_q  <= '0;
      tx_byte_q <= '0;
    end else begin
      tx_stb_q <= dat_wr;
      if (|dat_wr) tx_byte_q <= bus_wdata_i;
    end
  end

  assign tx_stb_o  = tx_stb_q;
  assign tx_byte_o = tx_byte_q;
  assign unused_wr = ^wregs;

  AST_STAT_TXE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd[0] && ptr[0] == '0) |-> bus_rdata_o[STAT_TXE]); // R6
  AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && off != OFF_CMD && off != OFF_DATA) |-> (bus_rdata_o == '0)); // R2
endmodule

// File: tb/sim_scc_regif.sv
module sim_scc_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  rx_push = '0;
  logic [15:0] rx_byte = '0;
  logic [1:0]  tx_stb;
  logic [7:0]  tx_byte;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [8:0] tx_q[$];

  always #2 clk = ~clk;

  scc_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_push_i(rx_push), .rx_byte_i(rx_byte), .tx_stb_o(tx_stb),
    .tx_byte_o(tx_byte), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares results as the design produces them
  always @(negedge clk) begin
    if (bus_rd && !bus_wr) begin
      if (rd_exp_q.size() == 0) chk("read without expectation", {1'b0, bus_rdata}, 9'h1ff);
      else chk(rd_tag_q.pop_front(), {1'b0, bus_rdata}, {1'b0, rd_exp_q.pop_front()});
    end
    for (int c = 0; c < 2; c++) begin
      if (tx_stb[c]) begin
        if (tx_q.size() == 0) chk("R8 unexpected strobe", {c[0], tx_byte}, 9'h1ff);
        else chk("R8 transmit byte", {c[0], tx_byte}, tx_q.pop_front());
      end
    end
  end

  task automatic op_idle();
    bus_wr = 1'b0; bus_rd = 1'b0; rx_push = '0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    op_idle();
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    op_idle();
  endtask

  task automatic wr_reg(input bit ch, input logic [3:0] r, input logic [7:0] v);
    bus_write({ch, 3'd1}, {4'h0, r});
    bus_write({ch, 3'd1}, v);
  endtask

  task automatic rd_reg(input bit ch, input logic [3:0] r, input logic [7:0] exp, input string tag);
    bus_write({ch, 3'd1}, {4'h0, r});
    bus_read({ch, 3'd1}, exp, tag);
  endtask

  task automatic data_wr(input bit ch, input logic [7:0] d);
    tx_q.push_back({ch, d});
    bus_write({ch, 3'd5}, d);
  endtask

  task automatic push_rx(input bit ch, input logic [7:0] d);
    @(posedge clk); #1;
    rx_push[ch] = 1'b1; rx_byte[ch*8 +: 8] = d;
    @(posedge clk); #1;
    op_idle();
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(negedge clk);
    chk(tag, {8'h0, irq}, {8'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq after reset", {8'h0, irq}, 9'h0);
    chk("R1 tx strobe after reset", {7'h0, tx_stb}, 9'h0);
    rd_reg(0, 0, 8'h04, "R1 R6 status A empty");
    rd_reg(1, 0, 8'h04, "R1 R6 status B empty");
    rd_reg(0, 3, 8'h00, "R1 pending clear");
    rd_reg(0, 12, 8'h00, "R1 write reg zero");

    // R2 unused offsets
    bus_write(4'h2, 8'h0c);
    bus_write(4'hb, 8'h0c);
    bus_read(4'h2, 8'h00, "R2 offset 2 reads zero");
    bus_read(4'h0, 8'h00, "R2 offset 0 reads zero");
    wr_reg(0, 13, 8'h5a);
    rd_reg(0, 13, 8'h5a, "R2 stray write ignored");

    // R3 R5 pointer sequence and mirrors
    wr_reg(1, 12, 8'ha5);
    rd_reg(1, 12, 8'ha5, "R3 write then mirror");
    rd_reg(0, 12, 8'h00, "R2 channel separation");
    wr_reg(1, 13, 8'h3c);
    rd_reg(1, 13, 8'h3c, "R5 mirror 13");
    rd_reg(1, 2, 8'h00, "R5 reg 2 zero");
    rd_reg(1, 3, 8'h00, "R5 channel B reg 3 zero");
    rd_reg(0, 7, 8'h00, "R5 reg 7 zero");
    rd_reg(1, 1, 8'h00, "R6 reg 1 zero");

    // R4 command read resets pointer
    bus_write(4'h1, 8'h0d);
    bus_read(4'h1, 8'h5a, "R4 read named register");
    bus_write(4'h1, 8'h0d);
    bus_write(4'h1, 8'h11);
    rd_reg(0, 13, 8'h11, "R4 select mode restored");
    bus_read(4'h1, 8'h04, "R4 idle pointer reads reg 0");

    // R8 transmit strobe, no loopback
    data_wr(0, 8'h41);
    data_wr(1, 8'h42);
    rd_reg(0, 0, 8'h04, "R9 no loopback when off");

    // R7 fifo order, empty read, full drop
    push_rx(0, 8'h10); push_rx(0, 8'h11); push_rx(0, 8'h12);
    rd_reg(0, 0, 8'h05, "R6 receive available");
    rd_reg(1, 0, 8'h04, "R6 other channel empty");
    bus_read(4'h5, 8'h10, "R7 pop order");
    bus_read(4'h5, 8'h11, "R7 pop order");
    bus_read(4'h5, 8'h12, "R7 pop order");
    bus_read(4'h5, 8'h00, "R7 empty read zero");
    for (int i = 0; i < 9; i++) push_rx(1, 8'h20 + 8'(i));
    for (int i = 0; i < 8; i++) bus_read(4'hd, 8'h20 + 8'(i), "R7 full fifo contents");
    bus_read(4'hd, 8'h00, "R7 push to full dropped");

    // R9 loopback and priority over external push
    wr_reg(1, 14, 8'h10);
    data_wr(1, 8'h77);
    bus_read(4'hd, 8'h77, "R9 looped byte");
    tx_q.push_back({1'b1, 8'h88});
    @(posedge clk); #1;
    bus_addr = 4'hd; bus_wdata = 8'h88; bus_wr = 1'b1;
    rx_push[1] = 1'b1; rx_byte[15:8] = 8'h99;
    @(posedge clk); #1;
    op_idle();
    bus_read(4'hd, 8'h88, "R9 loopback wins");
    bus_read(4'hd, 8'h00, "R9 external byte dropped");
    bus_read(4'h5, 8'h00, "R9 channel A untouched");
    wr_reg(1, 14, 8'h00);

    // R10 receive pending and interrupt
    wr_reg(0, 9, 8'h08);
    wr_reg(0, 1, 8'h08);
    irq_is(1'b0, "R10 no data no irq");
    push_rx(1, 8'h55);
    repeat (2) @(posedge clk);
    irq_is(1'b1, "R10 irq on channel B data");
    rd_reg(0, 3, 8'h04, "R10 pending bit B");
    bus_read(4'hd, 8'h55, "R7 pop pending byte");
    repeat (2) @(posedge clk);
    irq_is(1'b0, "R12 irq gone after drain");

    // R12 clear then re-arm
    push_rx(0, 8'h61); push_rx(0, 8'h62);
    repeat (2) @(posedge clk);
    irq_is(1'b1, "R10 irq on channel A data");
    bus_read(4'h5, 8'h61, "R7 pop first");
    irq_is(1'b0, "R12 cleared by data read");
    irq_is(1'b1, "R12 re-armed next cycle");
    rd_reg(0, 3, 8'h20, "R10 pending bit A");
    bus_read(4'h5, 8'h62, "R7 pop second");
    repeat (2) @(posedge clk);
    irq_is(1'b0, "R12 irq low when empty");

    // R11 transmit pending
    wr_reg(0, 1, 8'h02);
    data_wr(0, 8'h31);
    irq_is(1'b1, "R11 transmit irq A");
    rd_reg(0, 3, 8'h10, "R11 pending bit A");
    irq_is(1'b0, "R12 cleared by reg 3 read");
    data_wr(1, 8'h32);
    irq_is(1'b0, "R11 channel B enable off");
    rd_reg(0, 3, 8'h00, "R11 no pending B");
    wr_reg(1, 1, 8'h02);
    data_wr(1, 8'h33);
    irq_is(1'b1, "R11 transmit irq B");
    rd_reg(0, 3, 8'h02, "R11 pending bit B");
    wr_reg(0, 9, 8'h00);
    data_wr(0, 8'h34);
    irq_is(1'b0, "R11 master off");
    rd_reg(0, 3, 8'h00, "R11 master off no pending");

    repeat (3) @(posedge clk);
    chk("R8 all strobes seen", {1'b0, 8'(tx_q.size())}, 9'h0);
    chk("R4 all reads seen", {1'b0, 8'(rd_exp_q.size())}, 9'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule